// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Unit

This block is a pipelined arithmetic unit for a processor datapath. Each operand word is split into byte lanes. Every byte of the first operand is read as an unsigned number, and the byte in the same lane of the second operand is read as a two's-complement number. The unit multiplies each lane pair, adds the lane products at full precision and returns the signed total, sign-extended to the full word width.

Issue logic presents an issue strobe, the two operands, a guard word and a destination register index. Three clock edges later the unit returns the sum, the index and a write-enable for the register file. The write-enable is raised only if the operation was issued and bit 0 of its guard was set; the rest of the guard word has no effect. A new operation can be accepted on every cycle.

Parameters set the lane width, the lane count, the index width, the guard width and the multiplier style (native multiply or shift-and-add). Elaboration checks reject combinations that would lose precision.

Top module: `mdp_dot4`

## Requirements
- R1: `wb_data` is the sum over k = 0..3 of the product of byte k of `opa` and byte k of `opb`, where byte k occupies bits 8k+7 down to 8k. Lanes are never crossed.
- R2: Bytes of `opa` are unsigned (0..255) and bytes of `opb` are signed (-128..127). For example, an `opa` byte of 0xff counts as 255 and an `opb` byte of 0xff counts as -1.
- R3: The total is exact and is returned as a two's-complement 32-bit value, sign-extended. It lies between -130560 (0xfffe0200) and +129540.
- R4: `wb_en` is 1 exactly when the operation was issued with `issue_vld`=1 and `guard` bit 0 = 1. Guard bits 31..1 have no effect.
- R5: Inputs sampled at a rising edge appear on `wb_en`, `wb_idx` and `wb_data` just after the third rising edge counting that one, which is a latency of 3 cycles.
- R6: `wb_idx` equals the `dst_idx` that was issued with the same operation.
- R7: While `rst` is high at a rising edge, every pipeline stage is emptied. Operations issued during reset, and operations in flight when reset is applied, never raise `wb_en`.
- R8: Operations issued on consecutive cycles each produce their own result, in order, one per cycle, with no stall.
- R9: `opa`=0x0a0a1414 with `opb`=0x0afb14f6 gives 0x000000fa. `opa`=0x9c649c64 with `opb`=0x649c649c gives 0x00002bc0. `opa`=0xffffffff with `opb`=0x80808080 gives 0xfffe0200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; empties the pipeline |
| issue_vld | input | 1 | An operation is presented this cycle |
| opa | input | 32 | Operand whose bytes are unsigned |
| opb | input | 32 | Operand whose bytes are signed |
| guard | input | 32 | Predicate word; only bit 0 is used |
| dst_idx | input | 5 | Destination register index |
| wb_en | output | 1 | Register-file write enable |
| wb_idx | output | 5 | Destination index for the write |
| wb_data | output | 32 | Signed sum of the four lane products |

## Verification
The embedded properties check the following on every cycle:
- Each write-enable matches a guarded issue exactly three edges earlier, in both directions.
- The returned index is the one issued with that operation.
- Reset leaves the pipeline empty.
- Every result written lies in the legal signed range.
- A lane with a zero byte yields a zero product.
- A negative signed byte times a nonzero unsigned byte yields a negative product.

Whether the sum is arithmetically right, including the most negative corner, lane pairing and signedness per operand, can only be shown by the bench's scenarios. These are the directed vectors, operands built from the bytes 0x00/0x7f/0x80/0xff, and random back-to-back traffic with mixed guards and a mid-stream reset, all compared against an integer model.

// File: rtl/mdp_pkg.sv
package mdp_pkg;

   // Multiplier implementation styles selectable per lane
   localparam int MUL_NATIVE   = 0;
   localparam int MUL_SHIFTADD = 1;

   // Width of one unsigned-by-signed lane product with no loss
   function automatic int prod_width(input int byte_w);
      return 2 * byte_w + 1;
   endfunction

   // Width of the exact sum of a number of lane products
   function automatic int sum_width(input int byte_w, input int lanes);
      return prod_width(byte_w) + $clog2(lanes);
   endfunction

endpackage

// File: rtl/mdp_lane_mul.sv
module mdp_lane_mul
   import mdp_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int MUL_STYLE = MUL_NATIVE
) (
   input  logic                              clk,
   input  logic        [BYTE_W-1:0]          ua,
   input  logic signed [BYTE_W-1:0]          sb,
   output logic signed [2*BYTE_W:0]          prod_q
);
   localparam int PROD_W = prod_width(BYTE_W);

   logic signed [PROD_W-1:0] prod_d;

   generate
      if (MUL_STYLE == MUL_NATIVE) begin : g_native
         logic signed [BYTE_W:0] ua_s;
         assign ua_s = $signed({1'b0, ua});
         always_comb begin
            prod_d = PROD_W'(ua_s) * PROD_W'(sb);
         end
      end else begin : g_shiftadd
         logic signed [PROD_W-1:0] sb_x;
         assign sb_x = PROD_W'(sb);
         always_comb begin
            prod_d = '0;
            for (int i = 0; i < BYTE_W; i++) begin
               if (ua[i]) begin
                  prod_d = prod_d + (sb_x <<< i);
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      prod_q <= prod_d;
   end

   // R2: a zero byte on either side gives a zero lane product
   a_r2_zero_lane: assert property (@(posedge clk)
      (ua == '0 || sb == '0) |=> (prod_q == '0));

   // R2: a negative signed byte times a nonzero unsigned byte is negative
   a_r2_sign_lane: assert property (@(posedge clk)
      (ua != '0 && sb[BYTE_W-1]) |=> prod_q[PROD_W-1]);

endmodule

// File: rtl/mdp_pair_add.sv
module mdp_pair_add #(
   parameter int IN_W = 17
) (
   input  logic                   clk,
   input  logic signed [IN_W-1:0] x,
   input  logic signed [IN_W-1:0] y,
   output logic signed [IN_W:0]   sum_q
);
   logic signed [IN_W:0] sum_d;

   always_comb begin
      sum_d = (IN_W+1)'(x) + (IN_W+1)'(y);
   end

   always_ff @(posedge clk) begin
      sum_q <= sum_d;
   end

   // R3: the sum of two equally signed inputs keeps that sign
   a_r3_pair_sign: assert property (@(posedge clk)
      (x[IN_W-1] && y[IN_W-1]) |=> sum_q[IN_W]);

endmodule

// File: rtl/mdp_ctl_pipe.sv
module mdp_ctl_pipe #(
   parameter int IDX_W = 5,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vld_in,
   input  logic             grd_in,
   input  logic [IDX_W-1:0] idx_in,
   output logic             wen_out,
   output logic [IDX_W-1:0] idx_out
);
   localparam int MID = DEPTH - 1;

   logic [MID-1:0]   vld_q;
   logic [MID-1:0]   grd_q;
   logic [IDX_W-1:0] idx_q [MID];
   logic             wen_q;
   logic [IDX_W-1:0] idx_o_q;

   generate
      for (genvar s = 0; s < MID; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst) vld_q[s] <= 1'b0;
               else     vld_q[s] <= vld_in;
               grd_q[s] <= grd_in;
               idx_q[s] <= idx_in;
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (rst) vld_q[s] <= 1'b0;
               else     vld_q[s] <= vld_q[s-1];
               grd_q[s] <= grd_q[s-1];
               idx_q[s] <= idx_q[s-1];
            end
         end
      end
   endgenerate

   // Output stage: the write enable is formed and registered here
   always_ff @(posedge clk) begin
      if (rst) wen_q <= 1'b0;
      else     wen_q <= vld_q[MID-1] & grd_q[MID-1];
      idx_o_q <= idx_q[MID-1];
   end

   assign wen_out = wen_q;
   assign idx_out = idx_o_q;

   // R7: a reset edge leaves every stage empty
   a_r7_pipe_empty: assert property (@(posedge clk)
      rst |=> (vld_q == '0 && !wen_q));

   // R8: a valid token advances one stage per cycle
   a_r8_advance: assert property (@(posedge clk) disable iff (rst)
      vld_q[0] |=> (MID > 1 ? vld_q[MID > 1 ? 1 : 0] : 1'b1));

endmodule

// File: rtl/mdp_dot4.sv
module mdp_dot4
   import mdp_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int LANES     = 4,
   parameter int IDX_W     = 5,
   parameter int GUARD_W   = 32,
   parameter int MUL_STYLE = MUL_NATIVE
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      issue_vld,
   input  logic [LANES*BYTE_W-1:0]   opa,
   input  logic [LANES*BYTE_W-1:0]   opb,
   input  logic [GUARD_W-1:0]        guard,
   input  logic [IDX_W-1:0]          dst_idx,
   output logic                      wb_en,
   output logic [IDX_W-1:0]          wb_idx,
   output logic [LANES*BYTE_W-1:0]   wb_data
);
   localparam int DATA_W  = LANES * BYTE_W;
   localparam int PROD_W  = prod_width(BYTE_W);
   localparam int PAIRS   = LANES / 2;
   localparam int PAIR_W  = PROD_W + 1;
   localparam int SUM_W   = sum_width(BYTE_W, LANES);
   localparam int LATENCY = 3;
   localparam int UMAX    = (1 << BYTE_W) - 1;
   localparam int SMAX    = (1 << (BYTE_W - 1)) - 1;
   localparam int SMIN    = -(1 << (BYTE_W - 1));

   // Elaboration-time parameter checks
   generate
      if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
         $error("mdp_dot4: LANES must be even and at least 2");
      end
      if (SUM_W > DATA_W) begin : g_bad_width
         $error("mdp_dot4: exact sum does not fit the result word");
      end
      if (MUL_STYLE != MUL_NATIVE && MUL_STYLE != MUL_SHIFTADD) begin : g_bad_style
         $error("mdp_dot4: unknown multiplier style");
      end
      if (GUARD_W < 1) begin : g_bad_guard
         $error("mdp_dot4: guard must be at least one bit");
      end
   endgenerate

   // Only guard bit 0 takes part; the rest is intentionally left out
   logic unused_guard_hi;
   generate
      if (GUARD_W > 1) begin : g_guard_hi
         assign unused_guard_hi = ^guard[GUARD_W-1:1];
      end else begin : g_guard_one
         assign unused_guard_hi = 1'b0;
      end
   endgenerate

   // Stage 1: lane products
   logic signed [PROD_W-1:0] prod [LANES];

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         mdp_lane_mul #(
            .BYTE_W   (BYTE_W),
            .MUL_STYLE(MUL_STYLE)
         ) u_mul (
            .clk   (clk),
            .ua    (opa[l*BYTE_W +: BYTE_W]),
            .sb    ($signed(opb[l*BYTE_W +: BYTE_W])),
            .prod_q(prod[l])
         );
      end
   endgenerate

   // Stage 2: pairwise partial sums
   logic signed [PAIR_W-1:0] pair [PAIRS];

   generate
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         mdp_pair_add #(
            .IN_W(PROD_W)
         ) u_add (
            .clk  (clk),
            .x    (prod[2*p]),
            .y    (prod[2*p+1]),
            .sum_q(pair[p])
         );
      end
   endgenerate

   // Stage 3: final sum, sign-extended to the result word
   logic signed [DATA_W-1:0] total_d;
   logic        [DATA_W-1:0] total_q;

   always_comb begin
      total_d = '0;
      for (int p = 0; p < PAIRS; p++) begin
         total_d = total_d + DATA_W'(pair[p]);
      end
   end

   always_ff @(posedge clk) begin
      total_q <= total_d;
   end

   // Control path travelling alongside the data
   mdp_ctl_pipe #(
      .IDX_W(IDX_W),
      .DEPTH(LATENCY)
   ) u_ctl (
      .clk    (clk),
      .rst    (rst),
      .vld_in (issue_vld),
      .grd_in (guard[0]),
      .idx_in (dst_idx),
      .wen_out(wb_en),
      .idx_out(wb_idx)
   );

   assign wb_data = total_q;

   // R4: a write only follows a guarded issue three edges earlier
   a_r4_write_needs_guard: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> $past(issue_vld && guard[0], 3));

   // R5: a guarded issue is written back after exactly three edges
   a_r5_latency: assert property (@(posedge clk) disable iff (rst)
      (issue_vld && guard[0]) |-> ##3 wb_en);

   // R6: the index returned is the one issued with the operation
   a_r6_index_follows: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> (wb_idx == $past(dst_idx, 3)));

   // R3: every written result lies within the exact signed range
   a_r3_result_range: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> ($signed(wb_data) >= DATA_W'(LANES * UMAX * SMIN) &&
                 $signed(wb_data) <= DATA_W'(LANES * UMAX * SMAX)));

   // R7: no write appears on the edge right after a reset edge
   a_r7_no_write_after_reset: assert property (@(posedge clk)
      rst |=> !wb_en);

endmodule

// File: tb/mdp_dot4_test.sv
module mdp_dot4_test;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        issue_vld = 1'b0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [31:0] guard = '0;
   logic [4:0]  dst_idx = '0;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [31:0] wb_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic        en;
      logic [4:0]  idx;
      logic [31:0] data;
      string       tag;
   } exp_t;

   exp_t q0, q1, q2;

   always #2 clk = ~clk;

   mdp_dot4 uut (
      .clk      (clk),
      .rst      (rst),
      .issue_vld(issue_vld),
      .opa      (opa),
      .opb      (opb),
      .guard    (guard),
      .dst_idx  (dst_idx),
      .wb_en    (wb_en),
      .wb_idx   (wb_idx),
      .wb_data  (wb_data)
   );

   // Integer model of the lane sum: unsigned opa bytes, signed opb bytes
   function automatic logic [31:0] ref_dot(input logic [31:0] a, input logic [31:0] b);
      int s = 0;
      for (int k = 0; k < 4; k++) begin
         int ua = int'(a[8*k +: 8]);
         int sb = int'($signed(b[8*k +: 8]));
         s += ua * sb;
      end
      return 32'(s);
   endfunction

   task automatic check_out();
      n_cmp++;
      if (wb_en !== q2.en) begin
         n_bad++;
         $display("FAIL %s wb_en: actual %b expected %b", q2.tag, wb_en, q2.en);
      end
      if (q2.en === 1'b1) begin
         n_cmp++;
         if (wb_idx !== q2.idx) begin
            n_bad++;
            $display("FAIL R6 wb_idx: actual %0d expected %0d", wb_idx, q2.idx);
         end
         n_cmp++;
         if (wb_data !== q2.data) begin
            n_bad++;
            $display("FAIL %s wb_data: actual %h expected %h", q2.tag, wb_data, q2.data);
         end
      end
   endtask

   // One cycle: check what is due now, then present the next operation
   task automatic cycle(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] g, input logic [4:0] idx,
                        input logic [31:0] want, input string tag, input logic r);
      @(negedge clk);
      check_out();
      q2 = q1;
      q1 = q0;
      q0.en   = v & g[0];
      q0.idx  = idx;
      q0.data = want;
      q0.tag  = tag;
      if (r) begin
         // R7: everything captured or in flight at a reset edge is dropped
         q0.en = 1'b0;
         q1.en = 1'b0;
         q2.en = 1'b0;
         q0.tag = "R7";
         q1.tag = "R7";
         q2.tag = "R7";
      end
      rst       = r;
      issue_vld = v;
      opa       = a;
      opb       = b;
      guard     = g;
      dst_idx   = idx;
   endtask

   task automatic op(input logic v, input logic [31:0] a, input logic [31:0] b,
                     input logic [31:0] g, input logic [4:0] idx, input string tag);
      cycle(v, a, b, g, idx, ref_dot(a, b), tag, 1'b0);
   endtask

   function automatic logic [7:0] edge_byte(input int sel);
      case (sel)
         0: return 8'h00;
         1: return 8'h7f;
         2: return 8'h80;
         default: return 8'hff;
      endcase
   endfunction

   function automatic logic [31:0] edge_word();
      logic [31:0] w;
      for (int k = 0; k < 4; k++) begin
         w[8*k +: 8] = edge_byte(int'($urandom_range(0, 3)));
      end
      return w;
   endfunction

   initial begin
      void'($urandom(32'd4242));
      q0 = '{1'b0, 5'd0, 32'd0, "R7"};
      q1 = q0;
      q2 = q0;

      // R7: operations presented during reset never write
      for (int i = 0; i < 4; i++) begin
         cycle(1'b1, 32'h01010101, 32'h01010101, 32'h1, 5'(i), 32'd0, "R7", 1'b1);
      end

      // R9: directed vectors with literal expected values
      cycle(1'b1, 32'h0a0a1414, 32'h0afb14f6, 32'h1, 5'd9,  32'h000000fa, "R9", 1'b0);
      cycle(1'b1, 32'h9c649c64, 32'h649c649c, 32'h1, 5'd11, 32'h00002bc0, "R9", 1'b0);
      cycle(1'b1, 32'hffffffff, 32'h80808080, 32'h1, 5'd12, 32'hfffe0200, "R9", 1'b0);

      // R4: guard bit 0 clear suppresses the write; upper bits ignored
      op(1'b1, 32'h0a0a1414, 32'h0afb14f6, 32'h0,        5'd10, "R4");
      op(1'b1, 32'h0a0a1414, 32'h0afb14f6, 32'hfffffffe, 5'd10, "R4");
      op(1'b1, 32'h12345678, 32'h9abcdef0, 32'hfffffffe, 5'd3,  "R4");
      op(1'b1, 32'h12345678, 32'h9abcdef0, 32'h80000001, 5'd4,  "R4");
      op(1'b0, 32'h12345678, 32'h9abcdef0, 32'h1,        5'd5,  "R4");

      // R1: one nonzero lane at a time shows lanes are not crossed
      for (int k = 0; k < 4; k++) begin
         op(1'b1, 32'h03 << (8*k), 32'hfe << (8*k), 32'h1, 5'(k), "R1");
      end
      op(1'b1, 32'h00000005, 32'h00000700, 32'h1, 5'd20, "R1");

      // R2: 0xff on each side, read with its own signedness
      op(1'b1, 32'h000000ff, 32'h00000001, 32'h1, 5'd21, "R2");
      op(1'b1, 32'h00000001, 32'h000000ff, 32'h1, 5'd22, "R2");
      op(1'b1, 32'hffffffff, 32'h7f7f7f7f, 32'h1, 5'd23, "R3");

      // R2, R3: operands built from boundary bytes, back to back
      for (int i = 0; i < 200; i++) begin
         op(1'b1, edge_word(), edge_word(), 32'h1, 5'($urandom_range(0, 31)), "R3");
      end

      // R8: random traffic with gaps and mixed guards
      for (int i = 0; i < 400; i++) begin
         logic v;
         v = ($urandom_range(0, 4) != 0);
         op(v, $urandom(), $urandom(), $urandom(), 5'($urandom_range(0, 31)), "R8");
      end

      // R7: reset in the middle of a stream drops all in-flight work
      op(1'b1, 32'h11111111, 32'h22222222, 32'h1, 5'd1, "R8");
      op(1'b1, 32'h33333333, 32'h44444444, 32'h1, 5'd2, "R8");
      cycle(1'b1, 32'h55555555, 32'h66666666, 32'h1, 5'd3, 32'd0, "R7", 1'b1);
      op(1'b1, 32'h77777777, 32'h88888888, 32'h1, 5'd4, "R5");

      // R5: drain; each result appears exactly three edges after issue
      for (int i = 0; i < 4; i++) begin
         op(1'b0, 32'h0, 32'h0, 32'h0, 5'd0, "R5");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule